// File: doc/BRIEF.md
# Draw State Group Executor

This block keeps a small table of state groups for a command front end. Every group names a fragment of command packets by pointer. It also carries a three-bit tag that says in which rendering modes it applies, and a pending flag. Software-side logic rewrites groups through a write port. Each write replaces the pointer and the tag of the group and marks it pending.

When a draw arrives, the front end reports two things: whether any primitive of the draw lands in the current tile, and which rendering mode is active. For a draw that lands in the tile, the executor hands out execute requests over a valid/ready port. Each request carries the group number and the fragment pointer. Only groups that are pending and whose tag admits the current mode get a request, and they go out lowest number first. Accepting a request clears the pending flag of that group. Pending groups that are skipped for the wrong mode stay pending for a later draw. A draw that misses the tile produces no requests at all. Writes that arrive while requests are being handed out are parked, and they take effect once the scan is over. A one-cycle done pulse closes every draw.

Top module: `draw_group_exec`

## Requirements
- R1: After reset there are no requests, done is low, draw_ready is high, and every group is clean, so a visible draw yields no requests.
- R2: A write made while no scan is busy replaces the pointer and tag of group wr_id and marks it pending. A second write to the same group before it executes fully supersedes the first, and the group executes once with the second content.
- R3: A draw is accepted when draw_valid and draw_ready are both high. A visible draw issues one request for each eligible group in ascending group number, carrying that group's number and pointer.
- R4: A group that is not pending gets no request, so a repeated draw with no writes in between issues nothing.
- R5: Tag bit 0 admits direct-to-memory rendering (draw_mode 0), bit 1 admits the binning pass (draw_mode 1) and bit 2 admits tile rendering (draw_mode 2). draw_mode 3 admits no group. A pending group whose tag bit for the current mode is clear is skipped and stays pending.
- R6: A draw with draw_visible low issues no requests and raises done in the cycle after acceptance. It leaves all pending flags unchanged.
- R7: While req_valid is high and req_ready is low, req_id and req_ptr hold steady. A group's pending flag clears only when its request is accepted.
- R8: A write that arrives while a scan still has requests to issue does not alter that scan. It is applied when the scan ends, with the group marked pending.
- R9: done is a single-cycle pulse, once per accepted draw, raised in the cycle after the scan runs out of eligible groups. draw_ready is low while a scan is under way.
- R10: With req_ready held high, the requests of one scan come in consecutive cycles, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Group write strobe |
| wr_id | input | $clog2(N_GROUPS) | Group number to write |
| wr_ptr | input | PTR_W | New fragment pointer |
| wr_tag | input | 3 | New mode tag (bit0 direct, bit1 binning, bit2 tile) |
| draw_valid | input | 1 | Draw offered |
| draw_visible | input | 1 | Draw has a primitive in the current tile |
| draw_mode | input | 2 | Rendering mode: 0 direct, 1 binning, 2 tile, 3 none |
| draw_ready | output | 1 | Executor can accept a draw |
| req_valid | output | 1 | Execute request present |
| req_ready | input | 1 | Consumer accepts the request |
| req_id | output | $clog2(N_GROUPS) | Group number of the request |
| req_ptr | output | PTR_W | Fragment pointer of the request |
| done | output | 1 | One-cycle end-of-draw pulse |

## Verification
The bench aims at the places where lazy replay goes wrong. A group that is skipped for the wrong mode must come back at a later draw in a matching mode, and a design that cleared pending flags at scan start would lose it for good. A write that lands in the middle of a scan must not change the pointer of the request in flight, and it must not vanish. An eager design would hand out the new pointer early or drop the update. The bench also checks the invisible-draw path, where a design that scanned anyway would issue stray requests. It checks back-pressure, where a design that advanced without acceptance would skip groups or let req_ptr move. Finally it checks a rewrite before execution, which must yield a single request carrying the newer pointer.

// File: rtl/dge_pkg.sv
package dge_pkg;

    typedef enum logic [1:0] {
        RM_DIRECT  = 2'd0,
        RM_BINNING = 2'd1,
        RM_TILE    = 2'd2,
        RM_NONE    = 2'd3
    } rmode_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_SCAN = 1'b1
    } seq_state_e;

    localparam int TAG_W = 3;

    function automatic logic mode_hit(input logic [TAG_W-1:0] tag, input rmode_e m);
        case (m)
            RM_DIRECT:  return tag[0];
            RM_BINNING: return tag[1];
            RM_TILE:    return tag[2];
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dge_table.sv
module dge_table
    import dge_pkg::*;
#(
    parameter int N_GROUPS = 8,
    parameter int PTR_W    = 32,
    localparam int IDW     = $clog2(N_GROUPS)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [IDW-1:0]                 wr_id,
    input  logic [PTR_W-1:0]               wr_ptr,
    input  logic [TAG_W-1:0]               wr_tag,
    input  logic                           defer,
    input  logic                           commit,
    input  logic                           clr_en,
    input  logic [IDW-1:0]                 clr_id,
    output logic [N_GROUPS-1:0][PTR_W-1:0] ent_ptr,
    output logic [N_GROUPS-1:0][TAG_W-1:0] ent_tag,
    output logic [N_GROUPS-1:0]            ent_pend
);

    logic [N_GROUPS-1:0][PTR_W-1:0] sh_ptr;
    logic [N_GROUPS-1:0][TAG_W-1:0] sh_tag;
    logic [N_GROUPS-1:0]            sh_vld;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_slot
        logic wr_hit;
        logic clr_hit;
        assign wr_hit  = wr_en  && (wr_id  == IDW'(g));
        assign clr_hit = clr_en && (clr_id == IDW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_ptr[g]  <= '0;
                ent_tag[g]  <= '0;
                ent_pend[g] <= 1'b0;
                sh_ptr[g]   <= '0;
                sh_tag[g]   <= '0;
                sh_vld[g]   <= 1'b0;
            end else begin
                if (clr_hit) begin
                    ent_pend[g] <= 1'b0;
                end
                if (defer) begin
                    if (wr_hit) begin
                        sh_ptr[g] <= wr_ptr;
                        sh_tag[g] <= wr_tag;
                        sh_vld[g] <= 1'b1;
                    end
                end else begin
                    if (commit && sh_vld[g]) begin
                        ent_ptr[g]  <= sh_ptr[g];
                        ent_tag[g]  <= sh_tag[g];
                        ent_pend[g] <= 1'b1;
                        sh_vld[g]   <= 1'b0;
                    end
                    if (wr_hit) begin
                        ent_ptr[g]  <= wr_ptr;
                        ent_tag[g]  <= wr_tag;
                        ent_pend[g] <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/dge_pick.sv
module dge_pick #(
    parameter int N_GROUPS = 8,
    localparam int IDW     = $clog2(N_GROUPS)
) (
    input  logic [N_GROUPS-1:0] elig,
    output logic                any,
    output logic [IDW-1:0]      idx
);

    always_comb begin
        any = |elig;
        idx = '0;
        for (int i = N_GROUPS - 1; i >= 0; i--) begin
            if (elig[i]) idx = IDW'(i);
        end
    end

endmodule

// File: rtl/dge_seq.sv
module dge_seq
    import dge_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   draw_valid,
    input  logic   draw_visible,
    input  rmode_e draw_mode,
    input  logic   any_elig,
    output logic   draw_ready,
    output logic   scanning,
    output logic   busy,
    output logic   finishing,
    output rmode_e mode_q,
    output logic   done
);

    seq_state_e state;

    assign scanning   = (state == SEQ_SCAN);
    assign busy       = scanning && any_elig;
    assign finishing  = scanning && !any_elig;
    assign draw_ready = (state == SEQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            mode_q <= RM_NONE;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (draw_valid) begin
                        if (draw_visible) begin
                            state  <= SEQ_SCAN;
                            mode_q <= draw_mode;
                        end else begin
                            done <= 1'b1;
                        end
                    end
                end
                SEQ_SCAN: begin
                    if (!any_elig) begin
                        state <= SEQ_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/draw_group_exec.sv
module draw_group_exec
    import dge_pkg::*;
#(
    parameter int N_GROUPS = 8,
    parameter int PTR_W    = 32,
    localparam int IDW     = $clog2(N_GROUPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDW-1:0]   wr_id,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [2:0]       wr_tag,
    input  logic             draw_valid,
    input  logic             draw_visible,
    input  logic [1:0]       draw_mode,
    output logic             draw_ready,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [IDW-1:0]   req_id,
    output logic [PTR_W-1:0] req_ptr,
    output logic             done
);

    logic [N_GROUPS-1:0][PTR_W-1:0] ent_ptr;
    logic [N_GROUPS-1:0][TAG_W-1:0] ent_tag;
    logic [N_GROUPS-1:0]            ent_pend;
    logic [N_GROUPS-1:0]            elig;
    logic                           any_elig;
    logic [IDW-1:0]                 pick_idx;
    logic                           scanning, busy, finishing;
    rmode_e                         mode_q;

    dge_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .draw_valid   (draw_valid),
        .draw_visible (draw_visible),
        .draw_mode    (rmode_e'(draw_mode)),
        .any_elig     (any_elig),
        .draw_ready   (draw_ready),
        .scanning     (scanning),
        .busy         (busy),
        .finishing    (finishing),
        .mode_q       (mode_q),
        .done         (done)
    );

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_elig
        assign elig[g] = scanning && ent_pend[g] && mode_hit(ent_tag[g], mode_q);
    end

    dge_pick #(.N_GROUPS(N_GROUPS)) u_pick (
        .elig (elig),
        .any  (any_elig),
        .idx  (pick_idx)
    );

    dge_table #(.N_GROUPS(N_GROUPS), .PTR_W(PTR_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_id    (wr_id),
        .wr_ptr   (wr_ptr),
        .wr_tag   (wr_tag),
        .defer    (busy),
        .commit   (finishing),
        .clr_en   (req_valid && req_ready),
        .clr_id   (pick_idx),
        .ent_ptr  (ent_ptr),
        .ent_tag  (ent_tag),
        .ent_pend (ent_pend)
    );

    assign req_valid = any_elig;
    assign req_id    = pick_idx;
    assign req_ptr   = ent_ptr[pick_idx];

endmodule

// File: rtl/draw_group_exec_chk.sv
module draw_group_exec_chk #(
    parameter int N_GROUPS = 8,
    parameter int PTR_W    = 32,
    localparam int IDW     = $clog2(N_GROUPS)
) (
    input logic             clk,
    input logic             rst,
    input logic             draw_valid,
    input logic             draw_visible,
    input logic             draw_ready,
    input logic             req_valid,
    input logic             req_ready,
    input logic [IDW-1:0]   req_id,
    input logic [PTR_W-1:0] req_ptr,
    input logic             done
);

    logic           seen;
    logic [IDW-1:0] last_id;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen    <= 1'b0;
            last_id <= '0;
        end else if (draw_valid && draw_ready) begin
            seen <= 1'b0;
        end else if (req_valid && req_ready) begin
            seen    <= 1'b1;
            last_id <= req_id;
        end
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_id) && $stable(req_ptr)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_req_busy_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !draw_ready);

    assert_ascending_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && seen) |-> (req_id > last_id));

    assert_hidden_done_R6: assert property (@(posedge clk) disable iff (rst)
        (draw_valid && draw_ready && !draw_visible) |=> (done && !req_valid));

endmodule

bind draw_group_exec draw_group_exec_chk #(.N_GROUPS(N_GROUPS), .PTR_W(PTR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .draw_valid   (draw_valid),
    .draw_visible (draw_visible),
    .draw_ready   (draw_ready),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_id       (req_id),
    .req_ptr      (req_ptr),
    .done         (done)
);

// File: tb/draw_group_exec_test.sv
`timescale 1ns/1ps
module draw_group_exec_test;
    localparam int N   = 8;
    localparam int PW  = 32;
    localparam int IDW = $clog2(N);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [IDW-1:0] wr_id = '0;
    logic [PW-1:0] wr_ptr = '0;
    logic [2:0] wr_tag = '0;
    logic draw_valid = 1'b0, draw_visible = 1'b0;
    logic [1:0] draw_mode = 2'd0;
    logic draw_ready, req_valid, done;
    logic req_ready = 1'b0;
    logic [IDW-1:0] req_id;
    logic [PW-1:0] req_ptr;

    always #2.5 clk = ~clk;

    draw_group_exec #(.N_GROUPS(N), .PTR_W(PW)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_id(wr_id), .wr_ptr(wr_ptr),
        .wr_tag(wr_tag), .draw_valid(draw_valid), .draw_visible(draw_visible),
        .draw_mode(draw_mode), .draw_ready(draw_ready), .req_valid(req_valid),
        .req_ready(req_ready), .req_id(req_id), .req_ptr(req_ptr), .done(done)
    );

    int n_checks = 0;
    int n_fails  = 0;

    logic [PW-1:0] m_ptr  [N];
    logic [2:0]    m_tag  [N];
    bit            m_pend [N];
    int            exp_id [N];
    logic [PW-1:0] exp_ptr[N];

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic bit bhit(input logic [2:0] t, input int m);
        return (m < 3) && t[m];
    endfunction

    task automatic write_group(input int id, input logic [PW-1:0] p, input logic [2:0] t);
        @(negedge clk);
        wr_en = 1'b1; wr_id = IDW'(id); wr_ptr = p; wr_tag = t;
        @(negedge clk);
        wr_en = 1'b0;
        m_ptr[id] = p; m_tag[id] = t; m_pend[id] = 1'b1;
    endtask

    task automatic run_draw(input string req, input bit vis, input int mode, input int stall,
                            input int wr_at, input int wid, input logic [PW-1:0] wp, input logic [2:0] wt);
        int ecnt = 0;
        int got = 0;
        int first_cyc = -1;
        int last_cyc = -1;
        int done_cyc = -1;
        bit prev_hold = 0;
        logic [IDW-1:0] prev_id = '0;
        logic [PW-1:0] prev_ptr = '0;
        if (vis) begin
            for (int g = 0; g < N; g++) begin
                if (m_pend[g] && bhit(m_tag[g], mode)) begin
                    exp_id[ecnt] = g; exp_ptr[ecnt] = m_ptr[g]; ecnt++;
                end
            end
        end
        @(negedge clk);
        draw_valid = 1'b1; draw_visible = vis; draw_mode = 2'(mode);
        #1 chk(req, "draw_ready before draw (R9)", 64'(draw_ready), 64'd1);
        @(negedge clk);
        draw_valid = 1'b0;
        for (int cyc = 0; cyc < 4 * N + 20; cyc++) begin
            if (cyc == wr_at) begin
                wr_en = 1'b1; wr_id = IDW'(wid); wr_ptr = wp; wr_tag = wt;
            end else begin
                wr_en = 1'b0;
            end
            req_ready = (stall == 0) ? 1'b1 : ((cyc % (stall + 1)) == stall);
            #1;
            if (prev_hold) begin
                chk(req, "held id (R7)", 64'(req_id), 64'(prev_id));
                chk(req, "held ptr (R7)", 64'(req_ptr), 64'(prev_ptr));
            end
            prev_hold = req_valid && !req_ready;
            prev_id = req_id; prev_ptr = req_ptr;
            if (req_valid) chk(req, "draw_ready low in scan (R9)", 64'(draw_ready), 64'd0);
            if (req_valid && req_ready) begin
                if (got < ecnt) begin
                    chk(req, "request id (R3)", 64'(req_id), 64'(exp_id[got]));
                    chk(req, "request ptr (R3)", 64'(req_ptr), 64'(exp_ptr[got]));
                end
                if (first_cyc < 0) first_cyc = cyc;
                last_cyc = cyc;
                got++;
            end
            if (done) begin
                done_cyc = cyc;
                @(negedge clk);
                wr_en = 1'b0;
                req_ready = 1'b0;
                #1 chk(req, "done one cycle (R9)", 64'(done), 64'd0);
                break;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        req_ready = 1'b0;
        chk(req, "request count", 64'(got), 64'(ecnt));
        chk(req, "done seen (R9)", 64'(done_cyc >= 0), 64'd1);
        if (!vis) chk(req, "hidden draw done cycle (R6)", 64'(done_cyc), 64'd0);
        if (stall == 0 && got > 1)
            chk(req, "back-to-back span (R10)", 64'(last_cyc - first_cyc), 64'(got - 1));
        for (int k = 0; k < ecnt; k++) m_pend[exp_id[k]] = 1'b0;
        if (wr_at >= 0) begin
            m_ptr[wid] = wp; m_tag[wid] = wt; m_pend[wid] = 1'b1;
        end
    endtask

    task automatic t_reset();
        #1;
        chk("R1", "req_valid", 64'(req_valid), 64'd0);
        chk("R1", "done", 64'(done), 64'd0);
        chk("R1", "draw_ready", 64'(draw_ready), 64'd1);
        run_draw("R1", 1, 2, 0, -1, 0, '0, '0);
    endtask

    task automatic t_basic();
        logic [2:0] tags [N] = '{3'd7, 3'd4, 3'd4, 3'd1, 3'd6, 3'd2, 3'd4, 3'd5};
        for (int g = 0; g < N; g++) write_group(g, 32'h1000 + g * 16, tags[g]);
        run_draw("R3", 1, 2, 0, -1, 0, '0, '0);
    endtask

    task automatic t_clean();
        run_draw("R4", 1, 2, 0, -1, 0, '0, '0);
    endtask

    task automatic t_modes();
        chk("R5", "group3 kept pending", 64'(m_pend[3]), 64'd1);
        run_draw("R5", 1, 0, 0, -1, 0, '0, '0);
        run_draw("R5", 1, 1, 0, -1, 0, '0, '0);
        write_group(2, 32'h2222, 3'd7);
        run_draw("R5", 1, 3, 0, -1, 0, '0, '0);
        run_draw("R5", 1, 2, 0, -1, 0, '0, '0);
    endtask

    task automatic t_hidden();
        write_group(6, 32'h6060, 3'd4);
        run_draw("R6", 0, 2, 0, -1, 0, '0, '0);
        run_draw("R6", 1, 2, 0, -1, 0, '0, '0);
    endtask

    task automatic t_stall();
        write_group(1, 32'h1111, 3'd4);
        write_group(4, 32'h4444, 3'd6);
        write_group(7, 32'h7777, 3'd4);
        run_draw("R7", 1, 2, 2, -1, 0, '0, '0);
    endtask

    task automatic t_defer();
        write_group(2, 32'hA002, 3'd4);
        write_group(5, 32'hA005, 3'd4);
        run_draw("R8", 1, 2, 3, 0, 5, 32'hB005, 3'd4);
        chk("R8", "group5 pending after scan", 64'(m_pend[5]), 64'd1);
        run_draw("R8", 1, 2, 0, -1, 0, '0, '0);
    endtask

    task automatic t_supersede();
        write_group(3, 32'hC003, 3'd1);
        write_group(3, 32'hD003, 3'd1);
        run_draw("R2", 1, 0, 0, -1, 0, '0, '0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fails++;
        $display("FAIL watchdog R9: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int g = 0; g < N; g++) begin
            m_ptr[g] = '0; m_tag[g] = '0; m_pend[g] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_clean();
        t_modes();
        t_hidden();
        t_stall();
        t_defer();
        t_supersede();
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule